// File: doc/BRIEF.md
# Direct-Sequence Chip Spreader

This block turns a slow serial data stream into a fast chip stream for direct-sequence spread spectrum. A linear feedback shift register runs through a maximal-length pseudo-noise sequence of 2^n - 1 chips. Every data bit occupies exactly one full period of that sequence. A 1 is sent as the sequence unchanged and a 0 is sent as its bitwise complement. The chip rate is therefore an odd multiple of the bit rate, for example 7000 chips/s for 1000 bits/s when n = 3.

The block has no clock divider of its own. It advances one chip on each clock cycle where the chip enable is high, so any upstream pacing circuit can set the chip rate, including one that divides by an odd or a fractional ratio. The data bit boundary is not taken from a counter. It is found when the shift register comes back to its seed state. On that chip the block takes in the next data bit and raises a one-cycle strobe, which asks the source for the following bit.

Top module: `dsss_spreader`

## Requirements
- R1: While reset is active and until the first enabled chip, chip_out, bit_strobe and chip_valid are 0. The register holds its seed, so the first enabled chip after reset is the first chip of a new bit.
- R2: The sequence period is 2^LFSR_W - 1 chips. Within one period every cyclic window of LFSR_W consecutive chips differs from the others and is nonzero. With the defaults (LFSR_W = 4, taps x^4+x^3+1, seed all ones), the chips of a 1 bit are 111101011001000, first chip on the left.
- R3: A data bit of 1 is sent as the sequence as it stands. A data bit of 0 is sent as the exact bitwise complement of that sequence.
- R4: bit_strobe is high for one cycle, once per period, in the same cycle as the first chip of each bit. Between two strobes there are exactly 2^LFSR_W - 1 enabled chips.
- R5: data_in is sampled only on the enabled edge that starts a period. Changes of data_in during the rest of the period have no effect on chip_out.
- R6: On cycles with chip_en low the block does not advance. chip_out holds its value, and bit_strobe and chip_valid stay 0.
- R7: chip_valid is high in exactly the cycle after each clock edge where chip_en is high.
- R8: The register never holds all zeros. An all-zero state is replaced by the seed on the next clock edge.
- R9: A chip produced on an enabled edge appears on chip_out one clock cycle after that edge. An assertion of reset part-way through a period restarts the sequence at its first chip.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; takes effect at once, released on the clock |
| chip_en | input | 1 | Advance one chip on this cycle |
| data_in | input | 1 | Serial data bit, taken in at each period start |
| chip_out | output | 1 | Spread chip stream |
| bit_strobe | output | 1 | First chip of a bit; requests the next data bit |
| chip_valid | output | 1 | chip_out was updated at the last edge |

## Verification
All three outputs are registered, so a chip, its strobe and its valid flag are due one clock after the rising edge where chip_en was high, and an idle cycle shows held outputs one clock later. The bench changes inputs at the falling edge and reads outputs at the next falling edge, which is exactly one rising edge later. After rst_n rises, reset is released internally two clocks later, so the bench waits three cycles before it drives the first chip. Checks in idle gaps are made at every falling edge of the gap. This confirms that nothing moves while the enable is low.

// File: rtl/dsss_pkg.sv
package dsss_pkg;

  localparam int unsigned MIN_W = 3;
  localparam int unsigned MAX_W = 8;

  // Feedback mask for a primitive polynomial of degree w.
  // Bit (w-1-i) is set when the coefficient of x^i is 1 (i < w).
  // The MSB of the state is the oldest sequence element.
  function automatic logic [MAX_W-1:0] tap_mask(input int unsigned w);
    logic [MAX_W-1:0] m;
    case (w)
      3:       m = 8'h05; // x^3+x^2+1
      4:       m = 8'h09; // x^4+x^3+1
      5:       m = 8'h12; // x^5+x^3+1
      6:       m = 8'h21; // x^6+x^5+1
      7:       m = 8'h41; // x^7+x^6+1
      8:       m = 8'h8E; // x^8+x^6+x^5+x^4+1
      default: m = 8'h09;
    endcase
    return m;
  endfunction

  // Width mask with the low w bits set.
  function automatic logic [MAX_W-1:0] width_mask(input int unsigned w);
    logic [MAX_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < MAX_W; i++) begin
      if (i < w) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Seed restricted to w bits, replaced by 1 if that leaves zero.
  function automatic logic [MAX_W-1:0] legal_seed(input logic [MAX_W-1:0] s,
                                                  input int unsigned w);
    logic [MAX_W-1:0] t;
    t = s & width_mask(w);
    if (t == '0) t = {{(MAX_W-1){1'b0}}, 1'b1};
    return t;
  endfunction

endpackage

// File: rtl/dsss_pn_lfsr.sv
module dsss_pn_lfsr
  import dsss_pkg::*;
#(
  parameter int unsigned     W    = 4,
  parameter logic [MAX_W-1:0] SEED = 8'hFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] state,
  output logic         pn_bit,
  output logic         at_seed
);

  localparam logic [MAX_W-1:0] TAPS_FULL = tap_mask(W);
  localparam logic [MAX_W-1:0] SEED_FULL = legal_seed(SEED, W);
  localparam logic [W-1:0]     TAPS      = TAPS_FULL[W-1:0];
  localparam logic [W-1:0]     SEED_W    = SEED_FULL[W-1:0];

  generate
    if (W < MIN_W || W > MAX_W) begin : g_bad_width
      $error("dsss_pn_lfsr: width out of range");
    end
  endgenerate

  logic [W-1:0] state_q;
  logic [W-1:0] state_d;
  logic         feedback;
  logic         is_zero;

  always_comb begin
    feedback = ^(state_q & TAPS);
    is_zero  = (state_q == '0);
    if (is_zero) begin
      state_d = SEED_W;
    end else if (step) begin
      state_d = {state_q[W-2:0], feedback};
    end else begin
      state_d = state_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED_W;
    end else begin
      state_q <= state_d;
    end
  end

  assign state   = state_q;
  assign pn_bit  = state_q[W-1];
  assign at_seed = (state_q == SEED_W);

endmodule

// File: rtl/dsss_bit_framer.sv
module dsss_bit_framer (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic at_seed,
  input  logic data_in,
  output logic cur_bit,
  output logic strobe
);

  logic boundary;
  logic bit_q;
  logic bit_d;
  logic strobe_q;
  logic strobe_d;

  always_comb begin
    boundary = step && at_seed;
    bit_d    = boundary ? data_in : bit_q;
    strobe_d = boundary;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q    <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      bit_q    <= bit_d;
      strobe_q <= strobe_d;
    end
  end

  // The bit for the current chip: new data on the first chip, held after.
  assign cur_bit = bit_d;
  assign strobe  = strobe_q;

endmodule

// File: rtl/dsss_chip_mixer.sv
module dsss_chip_mixer (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic pn_bit,
  input  logic cur_bit,
  output logic chip,
  output logic valid
);

  logic chip_q;
  logic chip_d;
  logic valid_q;
  logic valid_d;

  always_comb begin
    chip_d  = step ? (pn_bit ^ ~cur_bit) : chip_q;
    valid_d = step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chip_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      chip_q  <= chip_d;
      valid_q <= valid_d;
    end
  end

  assign chip  = chip_q;
  assign valid = valid_q;

endmodule

// File: rtl/dsss_spreader.sv
module dsss_spreader
  import dsss_pkg::*;
#(
  parameter int unsigned      LFSR_W = 4,
  parameter logic [MAX_W-1:0] SEED   = 8'hFF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_en,
  input  logic data_in,
  output logic chip_out,
  output logic bit_strobe,
  output logic chip_valid
);

  logic              rst_meta_q;
  logic              rst_sync_q;
  logic [LFSR_W-1:0] lfsr_state;
  logic              pn_bit;
  logic              at_seed;
  logic              cur_bit;
  logic              step;

  // Reset takes effect at once and is released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  assign step = chip_en && rst_sync_q;

  dsss_pn_lfsr #(
    .W    (LFSR_W),
    .SEED (SEED)
  ) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .step    (step),
    .state   (lfsr_state),
    .pn_bit  (pn_bit),
    .at_seed (at_seed)
  );

  dsss_bit_framer u_framer (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .step    (step),
    .at_seed (at_seed),
    .data_in (data_in),
    .cur_bit (cur_bit),
    .strobe  (bit_strobe)
  );

  dsss_chip_mixer u_mixer (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .step    (step),
    .pn_bit  (pn_bit),
    .cur_bit (cur_bit),
    .chip    (chip_out),
    .valid   (chip_valid)
  );

endmodule

// File: rtl/dsss_spreader_chk.sv
module dsss_spreader_chk #(
  parameter int unsigned W = 4
) (
  input logic         clk,
  input logic         rst_ok,
  input logic         chip_en,
  input logic         chip_out,
  input logic         bit_strobe,
  input logic         chip_valid,
  input logic [W-1:0] state
);

  localparam int unsigned PERIOD = (1 << W) - 1;

  logic [8:0] cnt_q;
  logic       seen_q;

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (chip_valid) begin
      cnt_q  <= bit_strobe ? 9'd1 : cnt_q + 9'd1;
      seen_q <= seen_q | bit_strobe;
    end
  end

  a_r7_valid_follows_en: assert property (@(posedge clk) disable iff (!rst_ok)
    chip_en |=> chip_valid);

  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_ok)
    !chip_en |=> ($stable(chip_out) && !bit_strobe && !chip_valid));

  a_r4_strobe_with_chip: assert property (@(posedge clk) disable iff (!rst_ok)
    bit_strobe |-> chip_valid);

  a_r4_period_spacing: assert property (@(posedge clk) disable iff (!rst_ok)
    (chip_valid && bit_strobe && seen_q) |-> (cnt_q == 9'(PERIOD)));

  a_r8_never_zero: assert property (@(posedge clk) disable iff (!rst_ok)
    state != '0);

  a_r2_state_moves: assert property (@(posedge clk) disable iff (!rst_ok)
    chip_en |=> (state != $past(state)));

endmodule

bind dsss_spreader dsss_spreader_chk #(.W(LFSR_W)) u_chk (
  .clk        (clk),
  .rst_ok     (rst_sync_q),
  .chip_en    (chip_en),
  .chip_out   (chip_out),
  .bit_strobe (bit_strobe),
  .chip_valid (chip_valid),
  .state      (lfsr_state)
);

// File: tb/dsss_spreader_tb.sv
`timescale 1ns/1ps
module dsss_spreader_tb;

  localparam int PER = 15;
  localparam logic [14:0] PAT = 15'b111101011001000;

  logic clk;
  logic rst_n;
  logic chip_en;
  logic data_in;
  logic chip_out;
  logic bit_strobe;
  logic chip_valid;

  int n_checks;
  int n_fail;
  logic c_one  [PER];
  logic c_zero [PER];

  dsss_spreader u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .chip_en    (chip_en),
    .data_in    (data_in),
    .chip_out   (chip_out),
    .bit_strobe (bit_strobe),
    .chip_valid (chip_valid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n   = 1'b0;
    chip_en = 1'b0;
    data_in = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // One enabled chip; returns the outputs one edge later.
  task automatic one_chip(input logic d, output logic ch, output logic st, output logic vl);
    data_in = d;
    chip_en = 1'b1;
    @(negedge clk);
    chip_en = 1'b0;
    ch = chip_out;
    st = bit_strobe;
    vl = chip_valid;
  endtask

  // One full bit period with constant data; checks pattern and strobes.
  task automatic send_bit(input logic d, input string tag, output logic got [PER]);
    logic ch, st, vl;
    for (int k = 0; k < PER; k++) begin
      one_chip(d, ch, st, vl);
      got[k] = ch;
      check(ch == (PAT[14-k] ^ ~d), {tag, " R3 chip"}, ch, PAT[14-k] ^ ~d);
      check(st == (k == 0), {tag, " R4 strobe"}, st, (k == 0));
      check(vl == 1'b1, {tag, " R7 valid"}, vl, 1);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(chip_out == 1'b0, "R1 chip in reset", chip_out, 0);
    check(bit_strobe == 1'b0, "R1 strobe in reset", bit_strobe, 0);
    check(chip_valid == 1'b0, "R1 valid in reset", chip_valid, 0);
    do_reset();
    check(chip_out == 1'b0 && bit_strobe == 1'b0 && chip_valid == 1'b0,
          "R1 after release", {chip_out, bit_strobe, chip_valid}, 0);
  endtask

  task automatic t_one_and_zero();
    do_reset();
    send_bit(1'b1, "one", c_one);
    send_bit(1'b0, "zero", c_zero);
    for (int k = 0; k < PER; k++)
      check(c_zero[k] == ~c_one[k], "R3 complement", c_zero[k], ~c_one[k]);
  endtask

  task automatic t_windows();
    logic [3:0] w [PER];
    int ones;
    ones = 0;
    for (int k = 0; k < PER; k++) begin
      w[k] = {c_one[k], c_one[(k+1)%PER], c_one[(k+2)%PER], c_one[(k+3)%PER]};
      ones += int'(c_one[k]);
      check(w[k] != 4'd0, "R2 window nonzero", w[k], 1);
    end
    for (int a = 0; a < PER; a++)
      for (int b = a + 1; b < PER; b++)
        check(w[a] != w[b], "R2 windows distinct", w[a], -1);
    check(ones == 8, "R2 ones per period", ones, 8);
  endtask

  task automatic t_gaps();
    logic ch, st, vl;
    do_reset();
    for (int k = 0; k < PER; k++) begin
      one_chip(1'b1, ch, st, vl);
      check(ch == PAT[14-k], "R6 gapped chip", ch, PAT[14-k]);
      check(st == (k == 0), "R4 gapped strobe", st, (k == 0));
      for (int g = 0; g < (k % 3) + 1; g++) begin
        data_in = ~data_in;
        @(negedge clk);
        check(chip_out == ch, "R6 hold in gap", chip_out, ch);
        check(bit_strobe == 1'b0, "R6 no strobe in gap", bit_strobe, 0);
        check(chip_valid == 1'b0, "R7 no valid in gap", chip_valid, 0);
      end
    end
  endtask

  task automatic t_data_mid_period();
    logic ch, st, vl;
    do_reset();
    for (int k = 0; k < PER; k++) begin
      one_chip((k == 0) ? 1'b1 : 1'b0, ch, st, vl);
      check(ch == PAT[14-k], "R5 data ignored mid-period", ch, PAT[14-k]);
    end
    one_chip(1'b0, ch, st, vl);
    check(st == 1'b1, "R4 next boundary strobe", st, 1);
    check(ch == ~PAT[14], "R5 new bit taken at boundary", ch, ~PAT[14]);
  endtask

  task automatic t_stream();
    logic ch, st, vl;
    logic [4:0] bits;
    int strobes;
    bits = 5'b10011;
    strobes = 0;
    do_reset();
    for (int b = 0; b < 5; b++) begin
      for (int k = 0; k < PER; k++) begin
        one_chip(bits[4-b], ch, st, vl);
        strobes += int'(st);
        check(ch == (PAT[14-k] ^ ~bits[4-b]), "R3 stream chip", ch, PAT[14-k] ^ ~bits[4-b]);
        check(st == (k == 0), "R4 stream strobe", st, (k == 0));
      end
    end
    check(strobes == 5, "R4 strobe count", strobes, 5);
  endtask

  task automatic t_reset_mid();
    logic ch, st, vl;
    logic tmp [PER];
    do_reset();
    for (int k = 0; k < 6; k++) one_chip(1'b1, ch, st, vl);
    do_reset();
    check(chip_out == 1'b0 && chip_valid == 1'b0, "R9 reset mid-period clears",
          {chip_out, chip_valid}, 0);
    send_bit(1'b0, "R9 restart", tmp);
    one_chip(1'b1, ch, st, vl);
    check(st == 1'b1 && ch == PAT[14], "R8 sequence wraps to seed", {st, ch}, 3);
  endtask

  initial begin
    #(200000 * 4);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    n_checks = 0;
    n_fail   = 0;
    rst_n    = 1'b0;
    chip_en  = 1'b0;
    data_in  = 1'b0;
    t_reset();
    t_one_and_zero();
    t_windows();
    t_gaps();
    t_data_mid_period();
    t_stream();
    t_reset_mid();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule